// File: doc/BRIEF.md
# Discovery Request Responder for a Data-Object Mailbox

This block serves the discovery exchange of a data-object mailbox. When `start` is pulsed, it reads the pending request from an external request buffer. The buffer has an asynchronous read port, so data follows the address within the same cycle. The request is a two-DW header followed by one DW whose low byte is a protocol index. The block first checks the request length. If the length is accepted, it looks the index up in a parameter table of supported (vendor ID, object type) pairs. It then writes a three-DW response object into a response buffer and signals completion.

Table position 0 is always the discovery protocol itself. User entries therefore begin at index 1. An index past the table gives all-ones identifiers. Each response also names the index a requester should ask for next. That value returns to zero after the last valid entry, so software can walk the whole table in a loop. A request whose declared length is too short, or whose declared length does not match the number of DWs actually received, is dropped. In that case no response is written.

Top module: `disc_responder`

## Requirements
- R1: After reset, `done`, `success` and `rsp_we` are all 0.
- R2: The effective length is the low 18 bits of request DW1 (`req_rd_addr` = 1). If it is 1 or 2, the request is rejected. A reject raises `done` with `success` = 0 for one cycle, in the cycle after `start` is sampled, and makes no response write.
- R3: If the effective length differs from `req_cnt`, the request is rejected in the same way as R2.
- R4: A low-18-bit length field of zero means 2^18 DW. Bits [31:18] of DW1 are ignored.
- R5: An accepted request writes response DWs to `rsp_addr` 0, 1 and 2 on three consecutive cycles. The first write is 2 cycles after `start` is sampled. `done` with `success` = 1 follows for one cycle in the next cycle.
- R6: Response DW0 is {8'h00, DISC_TYPE, SIG_VENDOR}, with the vendor in bits [15:0] and the type in bits [23:16]. Response DW1 is 3.
- R7: For index 0 (request DW2 bits [7:0]), response DW2 reports SIG_VENDOR in bits [15:0] and DISC_TYPE in bits [23:16].
- R8: For an index i with 0 < i < N (N = NUM_PROTO + 1), response DW2 reports table entry i-1. Entry p occupies PROTO_TABLE[24p+23:24p], with the vendor in the low 16 bits and the type in the high 8 bits.
- R9: For an index i >= N, response DW2 reports vendor 16'hFFFF and type 8'hFF.
- R10: Response DW2 bits [31:24] hold the next index. It is 0 when i+1 = N, and (i+1) mod 256 otherwise.
- R11: A `start` that arrives while a request is being processed is ignored and does not disturb that request.
- R12: `success` is 0 whenever `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin processing the buffered request |
| req_rd_addr | output | REQ_AW | Request buffer DW address |
| req_rd_data | input | 32 | Request buffer read data, same cycle as the address |
| req_cnt | input | 19 | Number of DWs actually received for the request |
| rsp_we | output | 1 | Response buffer write enable |
| rsp_addr | output | RSP_AW | Response buffer DW address |
| rsp_data | output | 32 | Response buffer write data |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | With `done`: 1 = response written, 0 = rejected |

## Verification
Faults in the sequencer show up within a handful of cycles at the ports. A stuck or skipped state moves the `done` pulse away from cycle 1 or cycle 5 after `start`, or produces fewer than three writes, or produces writes after a reject. A wrong captured index or a table decode error changes only response DW2: a wrong identifier pair or next-index field. It appears in the third write, 4 cycles after `start`. Length decoding faults flip the accept/reject outcome, which is visible through `success` one cycle after `start` for a reject and five cycles after `start` for an accept.

// File: rtl/disc_pkg.sv
package disc_pkg;

  localparam int IDX_W       = 8;
  localparam int LEN_W       = 18;
  localparam int OLEN_W      = LEN_W + 1;
  localparam int MIN_REQ_LEN = 3;
  localparam int RSP_LEN     = 3;
  localparam int LEN_DW      = 1;
  localparam int IDX_DW      = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REJ,
    ST_FETCH,
    ST_WR0,
    ST_WR1,
    ST_WR2,
    ST_DONE
  } st_e;

  // Effective object length: a zero field stands for 2^18 DW.
  function automatic logic [OLEN_W-1:0] obj_len(input logic [31:0] dw);
    logic [LEN_W-1:0] f;
    f = dw[LEN_W-1:0];
    if (f == '0) return OLEN_W'(1) << LEN_W;
    return {1'b0, f};
  endfunction

  // Pack an identifier DW: vendor low, type next, extra byte on top.
  function automatic logic [31:0] pack_id(input logic [15:0] vid,
                                          input logic [7:0]  typ,
                                          input logic [7:0]  top);
    return {top, typ, vid};
  endfunction

  // Next index to request, wrapping after the last valid one.
  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i,
                                                input int unsigned       n);
    logic [IDX_W:0] s;
    s = {1'b0, i} + 1'b1;
    if (s == (IDX_W+1)'(n)) return '0;
    return s[IDX_W-1:0];
  endfunction

endpackage

// File: rtl/disc_ctrl.sv
module disc_ctrl
  import disc_pkg::*;
#(
  parameter int REQ_AW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [31:0]          rd_data,
  input  logic [OLEN_W-1:0]    req_cnt,
  output logic [REQ_AW-1:0]    rd_addr,
  output st_e                  st,
  output logic [IDX_W-1:0]     idx,
  output logic                 ev_bad,
  output logic                 done,
  output logic                 success
);

  logic [OLEN_W-1:0] eff_len;
  logic              ev_short;
  logic              ev_mismatch;
  logic              ev_take;
  st_e               st_nx;

  assign rd_addr     = (st == ST_FETCH) ? REQ_AW'(IDX_DW) : REQ_AW'(LEN_DW);
  assign eff_len     = obj_len(rd_data);
  assign ev_short    = eff_len < OLEN_W'(MIN_REQ_LEN);
  assign ev_mismatch = eff_len != req_cnt;
  assign ev_bad      = ev_short || ev_mismatch;
  assign ev_take     = (st == ST_IDLE) && start;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (start) st_nx = ev_bad ? ST_REJ : ST_FETCH;
      ST_REJ:   st_nx = ST_IDLE;
      ST_FETCH: st_nx = ST_WR0;
      ST_WR0:   st_nx = ST_WR1;
      ST_WR1:   st_nx = ST_WR2;
      ST_WR2:   st_nx = ST_DONE;
      ST_DONE:  st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      idx <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_FETCH) idx <= rd_data[IDX_W-1:0];
    end
  end

  assign done    = (st == ST_REJ) || (st == ST_DONE);
  assign success = (st == ST_DONE);

  // R2
  reject_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_take && ev_bad) |=> (done && !success));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FETCH) |=> (st == ST_WR0));

endmodule

// File: rtl/disc_lut.sv
module disc_lut
  import disc_pkg::*;
#(
  parameter int                      NUM_PROTO   = 3,
  parameter logic [NUM_PROTO*24-1:0] PROTO_TABLE = '0,
  parameter logic [15:0]             SIG_VENDOR  = 16'h0001,
  parameter logic [7:0]              DISC_TYPE   = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [15:0]      vid,
  output logic [7:0]       typ,
  output logic [IDX_W-1:0] nxt
);

  localparam int N = NUM_PROTO + 1;

  logic [NUM_PROTO-1:0] hit;
  logic [23:0]          sel;
  logic                 is_self;
  logic                 in_range;

  for (genvar p = 0; p < NUM_PROTO; p++) begin : g_hit
    assign hit[p] = (idx == IDX_W'(p + 1));
  end

  always_comb begin
    sel = '0;
    for (int p = 0; p < NUM_PROTO; p++) begin
      if (hit[p]) sel = sel | PROTO_TABLE[p*24 +: 24];
    end
  end

  assign is_self  = (idx == '0);
  assign in_range = ({1'b0, idx} < (IDX_W+1)'(N));

  always_comb begin
    if (is_self) begin
      vid = SIG_VENDOR;
      typ = DISC_TYPE;
    end else if (in_range) begin
      vid = sel[15:0];
      typ = sel[23:16];
    end else begin
      vid = 16'hFFFF;
      typ = 8'hFF;
    end
  end

  assign nxt = next_idx(idx, N);

  // R8
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R9
  out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, idx} >= (IDX_W+1)'(N)) |-> (vid == 16'hFFFF && typ == 8'hFF));

  // R10
  wrap_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, idx} == (IDX_W+1)'(N - 1)) |-> (nxt == '0));

endmodule

// File: rtl/disc_rsp_fmt.sv
module disc_rsp_fmt
  import disc_pkg::*;
#(
  parameter int          RSP_AW     = 2,
  parameter logic [15:0] SIG_VENDOR = 16'h0001,
  parameter logic [7:0]  DISC_TYPE  = 8'h00
) (
  input  st_e              st,
  input  logic [15:0]      vid,
  input  logic [7:0]       typ,
  input  logic [IDX_W-1:0] nxt,
  output logic             we,
  output logic [RSP_AW-1:0] addr,
  output logic [31:0]      data
);

  always_comb begin
    we   = 1'b0;
    addr = '0;
    data = '0;
    unique case (st)
      ST_WR0: begin
        we   = 1'b1;
        addr = RSP_AW'(0);
        data = pack_id(SIG_VENDOR, DISC_TYPE, 8'h00);
      end
      ST_WR1: begin
        we   = 1'b1;
        addr = RSP_AW'(1);
        data = 32'(RSP_LEN);
      end
      ST_WR2: begin
        we   = 1'b1;
        addr = RSP_AW'(2);
        data = pack_id(vid, typ, nxt);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/disc_responder.sv
module disc_responder
  import disc_pkg::*;
#(
  parameter int                      NUM_PROTO   = 3,
  parameter logic [NUM_PROTO*24-1:0] PROTO_TABLE = {24'h07_AB12, 24'h05_1E98, 24'h02_1E98},
  parameter logic [15:0]             SIG_VENDOR  = 16'h0001,
  parameter logic [7:0]              DISC_TYPE   = 8'h00,
  parameter int                      REQ_AW      = 4,
  parameter int                      RSP_AW      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [REQ_AW-1:0] req_rd_addr,
  input  logic [31:0]       req_rd_data,
  input  logic [18:0]       req_cnt,
  output logic              rsp_we,
  output logic [RSP_AW-1:0] rsp_addr,
  output logic [31:0]       rsp_data,
  output logic              done,
  output logic              success
);

  st_e              st;
  logic [IDX_W-1:0] idx;
  logic             ev_bad;
  logic [15:0]      vid;
  logic [7:0]       typ;
  logic [IDX_W-1:0] nxt;

  disc_ctrl #(.REQ_AW(REQ_AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rd_data (req_rd_data),
    .req_cnt (req_cnt),
    .rd_addr (req_rd_addr),
    .st      (st),
    .idx     (idx),
    .ev_bad  (ev_bad),
    .done    (done),
    .success (success)
  );

  disc_lut #(
    .NUM_PROTO   (NUM_PROTO),
    .PROTO_TABLE (PROTO_TABLE),
    .SIG_VENDOR  (SIG_VENDOR),
    .DISC_TYPE   (DISC_TYPE)
  ) u_lut (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (idx),
    .vid   (vid),
    .typ   (typ),
    .nxt   (nxt)
  );

  disc_rsp_fmt #(
    .RSP_AW     (RSP_AW),
    .SIG_VENDOR (SIG_VENDOR),
    .DISC_TYPE  (DISC_TYPE)
  ) u_fmt (
    .st   (st),
    .vid  (vid),
    .typ  (typ),
    .nxt  (nxt),
    .we   (rsp_we),
    .addr (rsp_addr),
    .data (rsp_data)
  );

  // R2
  reject_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !success) |-> !rsp_we);

  // R5
  write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_we && rsp_addr == RSP_AW'(0)) |=> (rsp_we && rsp_addr == RSP_AW'(1)));

  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_we && rsp_addr == RSP_AW'(2)) |=> (done && success));

  // R12
  success_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !success);

  // R6
  header_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_we && rsp_addr == RSP_AW'(1)) |-> (rsp_data == 32'd3));

endmodule

// File: tb/disc_responder_tb.sv
`timescale 1ns/1ps
module disc_responder_tb;

  localparam int NUM_PROTO = 3;
  localparam int N         = NUM_PROTO + 1;
  localparam int REQ_AW    = 4;
  localparam int RSP_AW    = 2;

  logic [15:0] tb_vid [NUM_PROTO] = '{16'h1E98, 16'h1E98, 16'hAB12};
  logic [7:0]  tb_typ [NUM_PROTO] = '{8'h02, 8'h05, 8'h07};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [REQ_AW-1:0] req_rd_addr;
  logic [31:0]       req_rd_data;
  logic [18:0]       req_cnt = '0;
  logic              rsp_we;
  logic [RSP_AW-1:0] rsp_addr;
  logic [31:0]       rsp_data;
  logic              done;
  logic              success;

  logic [31:0] req_mem [16];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  assign req_rd_data = req_mem[req_rd_addr];

  disc_responder #(
    .NUM_PROTO   (NUM_PROTO),
    .PROTO_TABLE ({24'h07_AB12, 24'h05_1E98, 24'h02_1E98}),
    .REQ_AW      (REQ_AW),
    .RSP_AW      (RSP_AW)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_rd_addr (req_rd_addr),
    .req_rd_data (req_rd_data),
    .req_cnt     (req_cnt),
    .rsp_we      (rsp_we),
    .rsp_addr    (rsp_addr),
    .rsp_data    (rsp_data),
    .done        (done),
    .success     (success)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_dw2(input logic [7:0] i);
    logic [15:0] v;
    logic [7:0]  t;
    logic [7:0]  nx;
    if (i == 8'd0) begin
      v = 16'h0001; t = 8'h00;
    end else if (int'(i) < N) begin
      v = tb_vid[int'(i) - 1]; t = tb_typ[int'(i) - 1];
    end else begin
      v = 16'hFFFF; t = 8'hFF;
    end
    nx = (int'(i) + 1 == N) ? 8'd0 : 8'((int'(i) + 1) % 256);
    return {nx, t, v};
  endfunction

  function automatic bit exp_ok(input logic [31:0] dw1, input logic [18:0] cnt);
    int unsigned l;
    l = (dw1[17:0] == 18'd0) ? 32'd262144 : 32'(dw1[17:0]);
    return (l >= 3) && (l == 32'(cnt));
  endfunction

  task automatic run_req(input logic [31:0] dw1, input logic [18:0] cnt,
                         input logic [7:0] idx, input bit poke, input string tag);
    bit          ok;
    int          nw;
    int          ndone;
    int          done_k;
    bit          succ_seen;
    bit          r12_bad;
    int          wk [3];
    logic [31:0] wd [3];
    ok = exp_ok(dw1, cnt);
    nw = 0; ndone = 0; done_k = -1; succ_seen = 0; r12_bad = 0;
    for (int j = 0; j < 3; j++) begin wk[j] = -1; wd[j] = '0; end
    @(negedge clk);
    req_mem[0] = 32'h0000_0001;
    req_mem[1] = dw1;
    req_mem[2] = {24'h0, idx};
    req_cnt    = cnt;
    start      = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) start = 1'b0;
      if (done) begin
        ndone++;
        done_k = k;
        succ_seen = success;
      end
      if (success && !done) r12_bad = 1;
      if (rsp_we) begin
        nw++;
        if (int'(rsp_addr) < 3) begin
          wk[int'(rsp_addr)] = k;
          wd[int'(rsp_addr)] = rsp_data;
        end
      end
      if (poke && k == 2) begin
        start = 1'b1;
        req_mem[1] = 32'd1;
        req_mem[2] = 32'hFF;
      end
      if (poke && k == 3) start = 1'b0;
    end
    chk(!r12_bad, "R12", {tag, " success without done"}, 32'(r12_bad), 0);
    chk(ndone == 1, poke ? "R11" : "R5", {tag, " done pulse count"}, 32'(ndone), 1);
    if (ok) begin
      chk(done_k == 5 && succ_seen, "R5", {tag, " accept done cycle"}, 32'(done_k), 5);
      chk(nw == 3 && wk[0] == 2 && wk[1] == 3 && wk[2] == 4, "R5",
          {tag, " write timing"}, 32'(nw), 3);
      chk(wd[0] == 32'h0000_0001, "R6", {tag, " header dw0"}, wd[0], 32'h0000_0001);
      chk(wd[1] == 32'd3, "R6", {tag, " header dw1"}, wd[1], 32'd3);
      chk(wd[2] == exp_dw2(idx),
          (idx == 0) ? "R7" : ((int'(idx) < N) ? "R8" : "R9"),
          {tag, " dw2 id"}, wd[2], exp_dw2(idx));
    end else begin
      chk(done_k == 1 && !succ_seen, (dw1[17:0] == 0 || dw1[17:0] > 2) ? "R3" : "R2",
          {tag, " reject pulse"}, 32'(done_k), 1);
      chk(nw == 0, "R2", {tag, " no writes on reject"}, 32'(nw), 0);
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) req_mem[i] = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !success && !rsp_we, "R1", "outputs under reset",
        {29'h0, done, success, rsp_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !success && !rsp_we, "R1", "outputs after reset",
        {29'h0, done, success, rsp_we}, 0);

    // directed corner cases
    run_req(32'd3, 19'd3, 8'd0, 0, "R7 idx0");
    run_req(32'd3, 19'd3, 8'd1, 0, "R8 idx1");
    run_req(32'd3, 19'd3, 8'd2, 0, "R8 idx2");
    run_req(32'd3, 19'd3, 8'd3, 0, "R10 last idx wraps");
    run_req(32'd3, 19'd3, 8'd4, 0, "R9 idx=N");
    run_req(32'd3, 19'd3, 8'd255, 0, "R10 idx255");
    run_req(32'd1, 19'd1, 8'd1, 0, "R2 len1");
    run_req(32'd2, 19'd2, 8'd1, 0, "R2 len2");
    run_req(32'd5, 19'd3, 8'd1, 0, "R3 mismatch");
    run_req(32'h0000_0000, 19'h40000, 8'd2, 0, "R4 zero len is max");
    run_req(32'h0000_0000, 19'd3, 8'd2, 0, "R4 zero len vs 3");
    run_req(32'hFFFC_0003, 19'd3, 8'd1, 0, "R4 upper bits ignored");
    run_req(32'hFFFC_0002, 19'd2, 8'd1, 0, "R4 upper bits short");
    run_req(32'd3, 19'd3, 8'd2, 1, "R11 start while busy");

    // constrained random
    for (int n = 0; n < 60; n++) begin
      logic [31:0] dw1;
      logic [18:0] cnt;
      logic [7:0]  ix;
      int          kind;
      kind = $urandom % 6;
      ix   = ($urandom % 5 == 0) ? 8'($urandom) : 8'($urandom % 7);
      case (kind)
        0, 1, 2: begin dw1 = 32'd3; cnt = 19'd3; end
        3:       begin dw1 = 32'(1 + $urandom % 2); cnt = 19'(dw1[17:0]); end
        4:       begin dw1 = 32'(4 + $urandom % 8); cnt = 19'd3; end
        default: begin dw1 = {14'($urandom), 18'd3}; cnt = 19'd3; end
      endcase
      run_req(dw1, cnt, ix, 0, "R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule